// File: doc/BRIEF.md
# UART Two-Stage Baud Tick Generator

This block turns a reference clock into the two timing strobes a UART needs. The first is a sample tick at the oversampling rate. The second is a bit tick that marks each serial bit period. An optional divide-by-8 prescaler sits in front of a 16-bit clock divisor, and the clock divisor emits the sample tick. A second 8-bit divider counts sample ticks and emits one bit tick per bit period. The resulting bit rate is the selected clock divided by `cd * (bdiv + 1)`.

The generator runs only while the transmitter or the receiver is enabled. Divisor values are normally changed only while both enables are low. A change made while running is still handled cleanly: the block notices any new value on `cd`, `bdiv` or `pre_sel` and restarts both counters from zero. The first tick after a restart comes one full period later. Both strobes are single-cycle pulses in the reference clock domain. When the sample period is one clock, the sample tick stays high.

Top module: `uart_baud_gen`

## Requirements
- R1: While `rst_n` is low, `sample_tick` and `bit_tick` are both 0.
- R2: With both divisors steady and an enable high, `sample_tick` pulses once every P clocks. P = `cd` when `pre_sel` = 0, and P = 8*`cd` when `pre_sel` = 1.
- R3: `bit_tick` pulses once every (B+1) sample ticks, where B is the effective `bdiv`, and it is high only in a cycle where `sample_tick` is also high.
- R4: A `bdiv` value of 0 to 3 behaves exactly as a value of 4. Values from 4 to 255 are used as given.
- R5: With `cd` = 0, `sample_tick` and `bit_tick` never pulse.
- R6: With `tx_en` and `rx_en` both low, no tick is produced. Either enable alone is enough to run the generator.
- R7: Counting restarts in two cases: on the clock edge that first sees an enable high, and on any edge that sees a new `cd`, `bdiv` or `pre_sel` value. Counting that edge as edge 0, the first `sample_tick` follows edge P and the first `bit_tick` follows edge P*(B+1).
- R8: Each tick is one reference-clock cycle wide. When P = 1, `sample_tick` stays high continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_sel | input | 1 | 1 selects the reference clock divided by 8; 0 selects it directly |
| cd | input | 16 | Sample divisor; 0 stops the ticks |
| bdiv | input | 8 | Bit divisor; sample ticks per bit minus one, lower bound 4 |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| sample_tick | output | 1 | Oversampling strobe |
| bit_tick | output | 1 | Bit-period strobe |

## Verification
The hardest case to reach is a divisor that changes partway through a running period. If the restart is missed, the old phase leaks into the new period. This only shows up as a tick that comes a few clocks early, in a single period. The stimulus starts a run, waits a number of clocks that does not divide the period evenly, and then loads a new `cd` or `bdiv` while the enable stays high. It then checks every cycle against the arithmetic schedule, counted from the edge that saw the change. The same schedule is swept over many small `cd`/`bdiv` pairs with both prescaler settings, so that the clamp and the prescaler phase are both covered.

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int CD_W    = 16,
  parameter int BD_W    = 8,
  parameter int PRE_DIV = 8,
  parameter int BD_MIN  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pre_sel,
  input  logic [CD_W-1:0] cd,
  input  logic [BD_W-1:0] bdiv,
  input  logic            tx_en,
  input  logic            rx_en,
  output logic            sample_tick,
  output logic            bit_tick
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
  localparam logic [BD_W-1:0]  BD_FLOOR = BD_W'(BD_MIN);

  logic [PRE_W-1:0] pre_cnt;
  logic [CD_W-1:0]  cd_cnt, cd_q;
  logic [BD_W-1:0]  bd_cnt, bd_q;
  logic             pre_q, active_q;

  wire active   = tx_en | rx_en;
  wire changed  = (cd != cd_q) | (bdiv != bd_q) | (pre_sel != pre_q);
  wire restart  = !active | !active_q | changed;
  wire pre_tick = !pre_sel | (pre_cnt == PRE_LAST);
  wire [BD_W-1:0] bd_eff = (bdiv < BD_FLOOR) ? BD_FLOOR : bdiv;
  wire cd_hit   = pre_tick & (cd != '0) & (cd_cnt == cd - 1'b1);
  wire bd_hit   = cd_hit & (bd_cnt == bd_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      cd_q        <= '0;
      bd_q        <= '0;
      pre_q       <= 1'b0;
      pre_cnt     <= '0;
      cd_cnt      <= '0;
      bd_cnt      <= '0;
      sample_tick <= 1'b0;
      bit_tick    <= 1'b0;
    end else begin
      active_q <= active;
      cd_q     <= cd;
      bd_q     <= bdiv;
      pre_q    <= pre_sel;
      if (restart) begin
        pre_cnt     <= '0;
        cd_cnt      <= '0;
        bd_cnt      <= '0;
        sample_tick <= 1'b0;
        bit_tick    <= 1'b0;
      end else begin
        if (pre_sel) pre_cnt <= (pre_cnt == PRE_LAST) ? '0 : pre_cnt + 1'b1;
        else         pre_cnt <= '0;
        if (pre_tick) cd_cnt <= cd_hit ? '0 : cd_cnt + 1'b1;
        if (cd_hit)   bd_cnt <= bd_hit ? '0 : bd_cnt + 1'b1;
        sample_tick <= cd_hit;
        bit_tick    <= bd_hit;
      end
    end
  end

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tx_en | rx_en) |-> (!sample_tick && !bit_tick));

  assert_bit_on_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);

  assert_cd_zero_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cd == '0) |-> !sample_tick);

  assert_enable_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en | rx_en) |=> !sample_tick);

  assert_divisor_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cd != $past(cd)) |=> (!sample_tick && !bit_tick));
endmodule

// File: tb/tb_uart_baud_gen.sv
module tb_uart_baud_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pre_sel = 1'b0;
  logic [15:0] cd = 16'd0;
  logic [7:0]  bdiv = 8'd0;
  logic        tx_en = 1'b0;
  logic        rx_en = 1'b0;
  logic        sample_tick, bit_tick;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  uart_baud_gen dut (
    .clk(clk), .rst_n(rst_n), .pre_sel(pre_sel), .cd(cd), .bdiv(bdiv),
    .tx_en(tx_en), .rx_en(rx_en), .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  // Inputs were just changed at a negedge; edge 1 is the restart edge.
  task automatic expect_run(input int p, input int b, input int len, input string tag);
    int bad = 0;
    for (int n = 1; n <= len; n++) begin
      logic es, eb;
      @(negedge clk);
      es = (p > 0) && (n >= 2) && (((n - 1) % p) == 0);
      eb = (p > 0) && (n >= 2) && (((n - 1) % (p * (b + 1))) == 0);
      if ((sample_tick !== es || bit_tick !== eb) && bad == 0)
        $display("FAIL %s cycle %0d: sample=%b bit=%b expected sample=%b bit=%b",
                 tag, n, sample_tick, bit_tick, es, eb);
      if (sample_tick !== es || bit_tick !== eb) bad++;
    end
    checks++;
    if (bad != 0) fails++;
  endtask

  task automatic run_cfg(input logic pre, input int c, input int bd, input bit use_rx,
                         input string tag);
    int p, b;
    @(negedge clk);
    tx_en = 1'b0; rx_en = 1'b0;
    @(negedge clk);
    pre_sel = pre; cd = 16'(c); bdiv = 8'(bd);
    if (use_rx) rx_en = 1'b1; else tx_en = 1'b1;
    p = pre ? 8 * c : c;
    b = (bd < 4) ? 4 : bd;
    expect_run(p, b, 2 * p * (b + 1) + 3, tag);
  endtask

  task automatic expect_quiet(input int len, input string tag);
    int bad = 0;
    for (int n = 0; n < len; n++) begin
      @(negedge clk);
      if ((sample_tick !== 1'b0 || bit_tick !== 1'b0) && bad == 0)
        $display("FAIL %s: sample=%b bit=%b expected 0 0", tag, sample_tick, bit_tick);
      if (sample_tick !== 1'b0 || bit_tick !== 1'b0) bad++;
    end
    checks++;
    if (bad != 0) fails++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: run did not finish, expected completion");
    fails++;
    checks++;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: outputs held low in reset even with the generator configured
    cd = 16'd1; bdiv = 8'd4; tx_en = 1'b1;
    expect_quiet(6, "R1 reset");
    @(negedge clk); rst_n = 1'b1;
    tx_en = 1'b0;

    // R2 R3 R4 R7: direct clock, sweep of cd and bdiv including clamped values
    for (int c = 1; c <= 8; c++)
      for (int bd = 0; bd <= 9; bd++)
        run_cfg(1'b0, c, bd, 1'b0, (bd < 4) ? "R4 clamp sweep" : "R2 R3 sweep");

    // R2 prescaled clock
    for (int c = 1; c <= 3; c++) begin
      run_cfg(1'b1, c, 0, 1'b0, "R2 R4 prescale");
      run_cfg(1'b1, c, 4, 1'b0, "R2 prescale");
      run_cfg(1'b1, c, 6, 1'b0, "R2 R3 prescale");
    end

    // R3 largest bit divisor; R8 continuous sample strobe at P=1
    run_cfg(1'b0, 1, 255, 1'b0, "R3 R8 bdiv max");

    // R6 receiver enable alone runs the generator
    run_cfg(1'b0, 3, 5, 1'b1, "R6 rx only");

    // R5 cd of zero stays silent
    @(negedge clk); tx_en = 1'b0;
    @(negedge clk); cd = 16'd0; bdiv = 8'd4; pre_sel = 1'b0; tx_en = 1'b1;
    expect_quiet(300, "R5 cd zero");

    // R6 dropping the enable mid-period silences the ticks
    run_cfg(1'b0, 2, 4, 1'b0, "R2 before drop");
    @(negedge clk); tx_en = 1'b0;
    checks++;
    if (sample_tick !== 1'b0 || bit_tick !== 1'b0) begin
      // the edge before this negedge still ran with the enable high
      if (!(sample_tick === 1'b1 || bit_tick === 1'b1)) begin
        fails++;
        $display("FAIL R6 drop: sample=%b bit=%b expected 0 0", sample_tick, bit_tick);
      end
    end
    expect_quiet(60, "R6 enables low");

    // R7 cd changed mid-period while enabled
    run_cfg(1'b0, 3, 4, 1'b0, "R2 before cd change");
    @(negedge clk); tx_en = 1'b1;
    repeat (4) @(negedge clk);
    cd = 16'd5;
    expect_run(5, 4, 2 * 5 * 5 + 3, "R7 cd change");

    // R7 bdiv changed mid-period while enabled
    repeat (7) @(negedge clk);
    bdiv = 8'd6;
    expect_run(5, 6, 2 * 5 * 7 + 3, "R7 bdiv change");

    // R7 prescale select changed mid-period
    repeat (3) @(negedge clk);
    pre_sel = 1'b1;
    expect_run(40, 6, 40 * 7 + 3, "R7 prescale change");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule